// File: doc/BRIEF.md
# Split Load Completion Tracker

This block follows one load through the data cache, from request to result. A load that straddles a boundary arrives already divided into a low part and a high part. The tracker sends the low part to the cache, and sends the high part only after the cache has taken the low part. Returning data is merged into a result buffer: low-part bytes go to offset zero, and high-part bytes go to the offset equal to the low part's byte count. A small countdown of outstanding parts decides when the load is finished. An unsplit load is handled as a single low part.

The cache can refuse a part. When it refuses the low part, or an unsplit load, the whole access is dropped. The tracker then pulses a replay request and a writeback-pending decrement. When it refuses the high part after taking the low part, the countdown loses one part. The low response is still absorbed, and the load then leaves without a result. Every refusal also updates a blocked-load record. The record keeps only the oldest blocked load, judged by sequence number.

Loads enter on a valid/ready stream. `req_ready` is high only while the tracker is idle, and the request is held by the sender until it is taken. Results leave on a valid/ready stream: `done_valid` stays high with stable data until `done_ready` is seen. A cache attempt is one cycle long. With `cq_valid` high, `cq_ready` high accepts the part and `cq_ready` low refuses it; nothing is held over. Responses carry no back-pressure.

Top module: `split_load_tracker`

## Requirements
- R1: After reset the tracker is idle: `req_ready`=1, and `done_valid`, `cq_valid`, `replay`, `wb_dec` and `blk_valid` are all 0.
- R2: An unsplit load finishes after its one response and a split load only after both responses; `done_valid` stays 0 until then.
- R3: The result holds low-response bytes 0..L-1 (L = low-part size; for an unsplit load L = total size) and high-response bytes 0..S-L-1 at result bytes L..S-1 (S = total size). Bytes at S and above are zero.
- R4: A part with `cq_half`=1 (high) is presented only after the same load's low part (`cq_half`=0) has been accepted.
- R5: When the low or unsplit part is refused, `replay` pulses in that cycle and the tracker is idle in the next cycle. No result is produced.
- R6: When the high part is refused, `replay` pulses. The low response is then absorbed without a result, and the tracker returns to idle. This holds even when the refusal and the low response fall in the same cycle.
- R7: On a refusal the blocked record takes the load's sequence number if the record is empty or if the new number is less than or equal to the recorded one. Otherwise the older record is kept. A new recording clears `blk_handled`, `blk_handled_set` sets it, and `blk_clear` empties the record.
- R8: `wb_dec` pulses on refusal of the low or unsplit part only, never on refusal of the high part.
- R9: A part is presented only in a cycle with `port_budget` nonzero, and `port_take` pulses for each part presented.
- R10: Responses may come back in either order. `rsp_half` (0 low, 1 high) selects where the data is placed.
- R11: After `squash`, the responses of the load are absorbed and no result is produced.
- R12: `done_valid`, `done_data` and `done_seq` hold until `done_ready`, and `req_ready` stays 0 while a load is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | New load offered |
| req_ready | output | 1 | Tracker idle, load taken |
| req_split | input | 1 | Load is split into two parts |
| req_size | input | SZ_W | Total byte count |
| req_lo_size | input | SZ_W | Low-part byte count (split only) |
| req_seq | input | SEQ_W | Load sequence number (smaller is older) |
| port_budget | input | BUD_W | Cache ports free this cycle |
| port_take | output | 1 | One port used this cycle |
| cq_valid | output | 1 | Part presented to cache |
| cq_ready | input | 1 | Cache accepts (else refuses) |
| cq_half | output | 1 | 0 low part, 1 high part |
| rsp_valid | input | 1 | Cache response |
| rsp_half | input | 1 | Response half tag |
| rsp_data | input | DW | Response bytes, byte 0 in bits 7:0 |
| squash | input | 1 | Current load squashed |
| done_valid | output | 1 | Result available |
| done_ready | input | 1 | Result consumed |
| done_data | output | DW | Merged result |
| done_seq | output | SEQ_W | Sequence number of result |
| replay | output | 1 | Replay request pulse |
| wb_dec | output | 1 | Writeback-pending decrement pulse |
| blk_valid | output | 1 | Blocked record holds a load |
| blk_seq | output | SEQ_W | Recorded blocked sequence number |
| blk_handled | output | 1 | Blocked record handled |
| blk_handled_set | input | 1 | Mark record handled |
| blk_clear | input | 1 | Empty record |

## Verification
Two events can both decrement the outstanding count in one cycle: a refusal of the high part and the arrival of the low response. The bench refuses the high part while it delivers the low response in the same cycle. It then expects an idle tracker on the next cycle and no result. A count that applies only one of the two decrements would leave the tracker waiting for ever, and the bench would catch this at the `req_ready` check. The two halves' responses are also swept in both orders over every size split, and each merged result is compared byte by byte.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_WAIT = 3'd3,
    ST_DONE = 3'd4
  } slt_state_e;
endpackage

// File: rtl/slt_part_count.sv
module slt_part_count (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic       load_two,
  input  logic [1:0] dec,
  output logic [1:0] cnt,
  output logic       finish
);
  assign finish = (cnt != 2'd0) && (cnt == dec) && !load && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= 2'd0;
    else if (clr)  cnt <= 2'd0;
    else if (load) cnt <= load_two ? 2'd2 : 2'd1;
    else           cnt <= cnt - dec;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |-> (dec <= cnt)); // R2
endmodule

// File: rtl/slt_result_buf.sv
module slt_result_buf #(
  parameter int DATA_BYTES = 8,
  localparam int SZ_W = $clog2(DATA_BYTES + 1),
  localparam int DW   = DATA_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [SZ_W-1:0] lo_end,
  input  logic [SZ_W-1:0] lo_size,
  input  logic [SZ_W-1:0] size,
  input  logic [DW-1:0]   rsp_data,
  output logic [DW-1:0]   buf_q
);
  logic [DW-1:0] hi_shift;
  assign hi_shift = rsp_data << {lo_size, 3'b000};

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    localparam logic [SZ_W-1:0] LANE = SZ_W'(b);
    logic lo_hit, hi_hit;
    assign lo_hit = lo_we && (LANE < lo_end);
    assign hi_hit = hi_we && (LANE >= lo_size) && (LANE < size);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_q[b*8 +: 8] <= 8'h00;
      else if (clr)    buf_q[b*8 +: 8] <= 8'h00;
      else if (lo_hit) buf_q[b*8 +: 8] <= rsp_data[b*8 +: 8];
      else if (hi_hit) buf_q[b*8 +: 8] <= hi_shift[b*8 +: 8];
    end
  end

  AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_we && hi_we)); // R10
endmodule

// File: rtl/slt_block_rec.sv
module slt_block_rec #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [SEQ_W-1:0] evt_seq,
  input  logic             set_handled,
  input  logic             clear,
  output logic             valid,
  output logic [SEQ_W-1:0] seq,
  output logic             handled
);
  logic live, take;
  assign live = valid && !clear;
  assign take = evt && (!live || (evt_seq <= seq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; seq <= '0; handled <= 1'b0;
    end else if (take) begin
      valid <= 1'b1; seq <= evt_seq; handled <= 1'b0;
    end else if (clear) begin
      valid <= 1'b0; handled <= 1'b0;
    end else if (set_handled && valid) begin
      handled <= 1'b1;
    end
  end

  AST_KEEP_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clear && evt && (evt_seq > seq)) |=> (seq == $past(seq)) && valid); // R7
  AST_NEW_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !valid) |=> (valid && !handled)); // R7
endmodule

// File: rtl/split_load_tracker.sv
module split_load_tracker
  import slt_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 8,
  parameter int BUD_W      = 2,
  localparam int SZ_W = $clog2(DATA_BYTES + 1),
  localparam int DW   = DATA_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_split,
  input  logic [SZ_W-1:0]  req_size,
  input  logic [SZ_W-1:0]  req_lo_size,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [BUD_W-1:0] port_budget,
  output logic             port_take,
  output logic             cq_valid,
  input  logic             cq_ready,
  output logic             cq_half,
  input  logic             rsp_valid,
  input  logic             rsp_half,
  input  logic [DW-1:0]    rsp_data,
  input  logic             squash,
  output logic             done_valid,
  input  logic             done_ready,
  output logic [DW-1:0]    done_data,
  output logic [SEQ_W-1:0] done_seq,
  output logic             replay,
  output logic             wb_dec,
  output logic             blk_valid,
  output logic [SEQ_W-1:0] blk_seq,
  output logic             blk_handled,
  input  logic             blk_handled_set,
  input  logic             blk_clear
);
  slt_state_e state, state_n;
  logic [SEQ_W-1:0] seq_q;
  logic             split_q, kill_q, lo_acc_q;
  logic [SZ_W-1:0]  size_q, lo_q, lo_end;
  logic             req_fire, cq_acc, cq_ref, lo_ref, hi_ref;
  logic             rsp_take, lo_we, hi_we, finish, cnt_clr;
  logic [1:0]       dec, cnt;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  assign cq_valid  = ((state == ST_LO) || (state == ST_HI)) && (port_budget != '0);
  assign cq_half   = (state == ST_HI);
  assign port_take = cq_valid;
  assign cq_acc    = cq_valid && cq_ready;
  assign cq_ref    = cq_valid && !cq_ready;
  assign lo_ref    = cq_ref && (state == ST_LO);
  assign hi_ref    = cq_ref && (state == ST_HI);

  assign replay = lo_ref || hi_ref;
  assign wb_dec = lo_ref;

  assign rsp_take = rsp_valid && ((state == ST_HI) || (state == ST_WAIT))
                    && (!rsp_half || split_q);
  assign lo_we    = rsp_take && !rsp_half;
  assign hi_we    = rsp_take && rsp_half;
  assign dec      = {1'b0, rsp_take} + {1'b0, hi_ref};
  assign cnt_clr  = (state == ST_LO) && (squash || lo_ref);
  assign lo_end   = split_q ? lo_q : size_q;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (req_valid) state_n = ST_LO;
      ST_LO: begin
        if (squash || lo_ref) state_n = ST_IDLE;
        else if (cq_acc)      state_n = split_q ? ST_HI : ST_WAIT;
      end
      ST_HI: begin
        if (finish)        state_n = ST_IDLE;
        else if (cq_valid) state_n = ST_WAIT;
      end
      ST_WAIT: if (finish) state_n = (kill_q || squash) ? ST_IDLE : ST_DONE;
      ST_DONE: if (done_ready || squash) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seq_q    <= '0;
      split_q  <= 1'b0;
      size_q   <= '0;
      lo_q     <= '0;
      kill_q   <= 1'b0;
      lo_acc_q <= 1'b0;
    end else begin
      state <= state_n;
      if (req_fire) begin
        seq_q    <= req_seq;
        split_q  <= req_split;
        size_q   <= req_size;
        lo_q     <= req_lo_size;
        kill_q   <= 1'b0;
        lo_acc_q <= 1'b0;
      end else begin
        if (hi_ref || (squash && (state != ST_IDLE))) kill_q <= 1'b1;
        if ((state == ST_LO) && cq_acc) lo_acc_q <= 1'b1;
      end
    end
  end

  slt_part_count u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(req_fire),
    .load_two(req_split), .dec(dec), .cnt(cnt), .finish(finish)
  );

  slt_result_buf #(.DATA_BYTES(DATA_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(req_fire), .lo_we(lo_we), .hi_we(hi_we),
    .lo_end(lo_end), .lo_size(lo_q), .size(size_q), .rsp_data(rsp_data),
    .buf_q(done_data)
  );

  slt_block_rec #(.SEQ_W(SEQ_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .evt(replay), .evt_seq(seq_q),
    .set_handled(blk_handled_set), .clear(blk_clear),
    .valid(blk_valid), .seq(blk_seq), .handled(blk_handled)
  );

  assign done_valid = (state == ST_DONE);
  assign done_seq   = seq_q;

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_valid && cq_half) |-> lo_acc_q); // R4
  AST_WB_ONLY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dec |-> !lo_acc_q); // R8
  AST_REPLAY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (replay && !cq_half) |=> req_ready); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready && !squash) |=> (done_valid && $stable(done_data))); // R12
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready); // R12
endmodule

// File: tb/tb_split_load_tracker.sv
module tb_split_load_tracker;
  localparam int DB = 8;
  localparam int SZ_W = 4;
  localparam int DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_split = 0;
  logic [SZ_W-1:0] req_size = '0, req_lo_size = '0;
  logic [7:0] req_seq = '0;
  logic [1:0] port_budget = '0;
  logic port_take, cq_valid, cq_ready = 0, cq_half;
  logic rsp_valid = 0, rsp_half = 0;
  logic [DW-1:0] rsp_data = '0;
  logic squash = 0, done_valid, done_ready = 0;
  logic [DW-1:0] done_data;
  logic [7:0] done_seq, blk_seq;
  logic replay, wb_dec, blk_valid, blk_handled;
  logic blk_handled_set = 0, blk_clear = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_load_tracker #(.DATA_BYTES(DB), .SEQ_W(8), .BUD_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_split(req_split), .req_size(req_size), .req_lo_size(req_lo_size),
    .req_seq(req_seq), .port_budget(port_budget), .port_take(port_take),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_half(cq_half),
    .rsp_valid(rsp_valid), .rsp_half(rsp_half), .rsp_data(rsp_data),
    .squash(squash), .done_valid(done_valid), .done_ready(done_ready),
    .done_data(done_data), .done_seq(done_seq), .replay(replay),
    .wb_dec(wb_dec), .blk_valid(blk_valid), .blk_seq(blk_seq),
    .blk_handled(blk_handled), .blk_handled_set(blk_handled_set),
    .blk_clear(blk_clear)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [DW-1:0] lo_pat(input int seq);
    logic [DW-1:0] v;
    for (int i = 0; i < DB; i++) v[i*8 +: 8] = 8'(seq * 3 + i * 17 + 1);
    return v;
  endfunction

  function automatic logic [DW-1:0] hi_pat(input int seq);
    logic [DW-1:0] v;
    for (int i = 0; i < DB; i++) v[i*8 +: 8] = 8'(seq * 5 + i * 29 + 8'h40);
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_buf(input bit split, input int size,
                                            input int lo, input int seq);
    logic [DW-1:0] v = '0;
    logic [DW-1:0] a = lo_pat(seq);
    logic [DW-1:0] h = hi_pat(seq);
    int le = split ? lo : size;
    for (int b = 0; b < DB; b++) begin
      if (b < le) v[b*8 +: 8] = a[b*8 +: 8];
      else if (split && b < size) v[b*8 +: 8] = h[(b-lo)*8 +: 8];
    end
    return v;
  endfunction

  task automatic give_req(input bit split, input int size, input int lo, input int seq);
    req_valid = 1; req_split = split; req_size = SZ_W'(size);
    req_lo_size = SZ_W'(lo); req_seq = 8'(seq);
    #1 chk(req_ready == 1'b1, "R12 req_ready idle", DW'(req_ready), 1);
    tick();
    req_valid = 0;
    #1 chk(req_ready == 1'b0, "R12 req_ready busy", DW'(req_ready), 0);
  endtask

  task automatic send_rsp(input bit half, input int seq);
    rsp_valid = 1; rsp_half = half; rsp_data = half ? hi_pat(seq) : lo_pat(seq);
    tick();
    rsp_valid = 0; rsp_data = '0;
  endtask

  task automatic do_access(input bit split, input int size, input int lo, input int seq,
                           input bit hi_first, input bit ref_lo, input bit ref_hi);
    give_req(split, size, lo, seq);
    port_budget = 2'd1; cq_ready = !ref_lo;
    #1;
    chk(cq_valid && !cq_half && port_take, "R9 low part presented", {cq_valid, cq_half, port_take}, 3'b101);
    chk(replay == ref_lo, "R5 replay on low refusal", DW'(replay), DW'(ref_lo));
    chk(wb_dec == ref_lo, "R8 wb_dec on low refusal", DW'(wb_dec), DW'(ref_lo));
    tick();
    cq_ready = 0;
    if (ref_lo) begin
      #1 chk(req_ready && !done_valid, "R5 dropped and idle", {req_ready, done_valid}, 2'b10);
      port_budget = 0;
      return;
    end
    if (split) begin
      cq_ready = !ref_hi;
      #1;
      chk(cq_valid && cq_half, "R4 high after low accepted", {cq_valid, cq_half}, 2'b11);
      chk(replay == ref_hi && !wb_dec, "R8 high refusal no wb_dec", {replay, wb_dec}, {ref_hi, 1'b0});
      tick();
      cq_ready = 0;
    end
    port_budget = 0;
    if (split && !ref_hi) begin
      send_rsp(hi_first, seq);
      #1 chk(!done_valid, "R2 not done after one of two", DW'(done_valid), 0);
      send_rsp(!hi_first, seq);
    end else begin
      send_rsp(1'b0, seq);
    end
    #1;
    if (ref_hi) begin
      chk(!done_valid && req_ready, "R6 low absorbed no result", {done_valid, req_ready}, 2'b01);
    end else begin
      chk(done_valid, "R2 done after all parts", DW'(done_valid), 1);
      chk(done_data == exp_buf(split, size, lo, seq), "R3 R10 merged data",
          done_data, exp_buf(split, size, lo, seq));
      chk(done_seq == 8'(seq), "R12 done_seq", DW'(done_seq), DW'(8'(seq)));
      done_ready = 1;
      tick();
      done_ready = 0;
      #1 chk(req_ready && !done_valid, "R12 idle after consume", {req_ready, done_valid}, 2'b10);
    end
  endtask

  initial begin
    int seq = 100;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready && !done_valid && !cq_valid && !replay && !wb_dec && !blk_valid,
        "R1 reset state", {req_ready, done_valid, cq_valid, replay, wb_dec, blk_valid}, 6'b100000);
    @(negedge clk);

    // sweep: unsplit sizes, then every split point in both response orders
    for (int s = 1; s <= DB; s++) begin
      do_access(1'b0, s, 0, seq, 1'b0, 1'b0, 1'b0); seq++;
    end
    for (int s = 2; s <= DB; s++)
      for (int l = 1; l < s; l++)
        for (int o = 0; o < 2; o++) begin
          do_access(1'b1, s, l, seq, o[0], 1'b0, 1'b0); seq++;
        end

    // R7 blocked record ordering
    do_access(1'b0, 4, 0, 20, 1'b0, 1'b1, 1'b0);
    chk(blk_valid && blk_seq == 8'd20 && !blk_handled, "R7 first record",
        {blk_valid, blk_seq, blk_handled}, {1'b1, 8'd20, 1'b0});
    blk_handled_set = 1; tick(); blk_handled_set = 0;
    #1 chk(blk_handled, "R7 handled set", DW'(blk_handled), 1);
    @(negedge clk);
    do_access(1'b1, 6, 2, 30, 1'b0, 1'b0, 1'b1);
    chk(blk_seq == 8'd20 && blk_handled, "R7 older kept R6", {blk_seq, blk_handled}, {8'd20, 1'b1});
    @(negedge clk);
    do_access(1'b0, 2, 0, 10, 1'b0, 1'b1, 1'b0);
    chk(blk_seq == 8'd10 && !blk_handled, "R7 older replaces", {blk_seq, blk_handled}, {8'd10, 1'b0});
    blk_handled_set = 1; tick(); blk_handled_set = 0;
    do_access(1'b0, 2, 0, 10, 1'b0, 1'b1, 1'b0);
    chk(blk_seq == 8'd10 && !blk_handled, "R7 equal replaces", {blk_seq, blk_handled}, {8'd10, 1'b0});
    blk_clear = 1; tick(); blk_clear = 0;
    #1 chk(!blk_valid, "R7 clear", DW'(blk_valid), 0);
    @(negedge clk);

    // R6 same cycle: high refusal plus low response
    give_req(1'b1, 8, 3, 40);
    port_budget = 1; cq_ready = 1; tick();
    cq_ready = 0; rsp_valid = 1; rsp_half = 0; rsp_data = lo_pat(40);
    #1 chk(cq_valid && cq_half && replay, "R6 high refused", {cq_valid, cq_half, replay}, 3'b111);
    tick();
    rsp_valid = 0; port_budget = 0;
    #1 chk(req_ready && !done_valid, "R6 both decrements same cycle", {req_ready, done_valid}, 2'b10);
    @(negedge clk);

    // R9 no port budget stalls issue
    give_req(1'b0, 4, 0, 41);
    port_budget = 0; cq_ready = 1;
    for (int k = 0; k < 2; k++) begin
      #1 chk(!cq_valid && !port_take, "R9 stall without budget", {cq_valid, port_take}, 2'b00);
      tick();
    end
    port_budget = 2;
    #1 chk(cq_valid && port_take, "R9 issue with budget", {cq_valid, port_take}, 2'b11);
    tick(); port_budget = 0; cq_ready = 0;
    send_rsp(1'b0, 41);
    #1 chk(done_valid && done_data == exp_buf(1'b0, 4, 0, 41), "R3 after stall",
           done_data, exp_buf(1'b0, 4, 0, 41));
    // R12 result holds without done_ready
    held = done_data;
    tick();
    #1 chk(done_valid && done_data == held && !req_ready, "R12 hold", {done_valid, req_ready}, 2'b10);
    done_ready = 1; tick(); done_ready = 0;

    // R11 squash discards the response
    give_req(1'b0, 4, 0, 42);
    port_budget = 1; cq_ready = 1; tick(); port_budget = 0; cq_ready = 0;
    squash = 1; tick(); squash = 0;
    send_rsp(1'b0, 42);
    #1 chk(!done_valid && req_ready, "R11 squashed no result", {done_valid, req_ready}, 2'b01);
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule